// File: doc/BRIEF.md
# Multi-Level Cell Program-Verify Write Sequencer

This block sequences a single write into one resistive memory cell that can hold one, two or four bits. A one-cycle start request carries a data value, a density selector and a limit on verify iterations. The block first drives the cell to a fully reset condition: a SET-sweep command, then straight away a RESET command. From that known high-resistance point it walks the cell down toward a narrow target window. It does this with partial SET commands, each followed by a settle interval and a check of a digitized resistance reading.

The target window is one slice of a 12-bit resistance code space, cut into equal slices whose number depends on the density. All three densities share one comparison path; only the window bounds move. An overshoot below the window forces a fresh start from the sweep/reset step. An iteration limit guarantees that every write ends, either with success or with an error flag.

Top module: `mlc_pv_seq`

## Requirements
- R1: `mode_i` selects the density: 2'b00 gives 2 slices, 2'b01 gives 4, and 2'b10 or 2'b11 gives 16 slices of the code space 0..4095. Slice width w = 4096/slices, the slice index k is the low log2(slices) bits of `data_i`, and the target window is the inclusive range [k*w, k*w+w-1].
- R2: Every accepted write starts with a SET-sweep command, and a RESET command follows in the very cycle the sweep ends. At most one of `sweep_o`, `reset_o` and `pset_o` is high in any cycle.
- R3: Every command stays high for PULSE_CYC cycles. After each partial SET the block waits SETTLE_CYC cycles and samples `res_i` at the end of the last of them. A further partial SET starts in the next cycle.
- R4: A sampled reading inside the target window ends the write: `done_o` is high for one cycle with `err_o` low, and no further command is issued.
- R5: A reading below the lower bound, with the limit not yet reached, restarts the write from the SET-sweep/RESET step and increments `retry_o`. `retry_o` is cleared at an accepted start and saturates at its maximum.
- R6: A reading above the upper bound, with the limit not yet reached, leads to another partial SET and no restart.
- R7: `max_pulses_i` is captured at start. It bounds the total number of partial SET pulses of one write, counted across restarts. A miss on the pulse that brings the total to the limit ends the write with `done_o` and `err_o` high together. A limit of 0 acts as 1. `err_o` is never high without `done_o`.
- R8: `start_i` is accepted only while the block is idle, which includes the done cycle. A start during a write is ignored and changes neither the command sequence nor the result.
- R9: `busy_o` is high from the cycle after an accepted start up to the done cycle, and is low in the done cycle. `done_o` lasts exactly one cycle.
- R10: `data_i` bits above the slice index width have no effect on the target window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle write request |
| mode_i | input | 2 | Density selector (00: 1 bit, 01: 2 bits, 10/11: 4 bits) |
| data_i | input | DATA_W | Value to store; its low bits pick the slice |
| max_pulses_i | input | CNT_W | Limit on partial SET pulses per write |
| res_i | input | RES_W | Digitized cell resistance reading |
| sweep_o | output | 1 | SET-sweep command |
| reset_o | output | 1 | RESET command |
| pset_o | output | 1 | Partial SET command |
| busy_o | output | 1 | Write in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Limit reached without entering the window (with done) |
| retry_o | output | RETRY_W | Restarts caused by overshoot in the current write |

## Verification
A behavioural cell model starts at code 4095 after each RESET. It lowers the code by a fixed step per partial SET and may use a different step after a restart. This lets directed writes place the reading above, inside or below the window at will. Single-bit, two-bit and four-bit writes with small steps separate correct slice sizing and index masking from wrong ones. Large first steps force overshoot and restart, and small steps with a low limit force the error path, including a limit that runs out across two restarts. Pulse-width, settle-gap, busy-length and order monitors tell a correct command timeline apart from one that drops or stretches a cycle. A start injected mid-write must leave the pulse count and result unchanged.

// File: rtl/mlc_pv_pkg.sv
package mlc_pv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SWEEP  = 3'd1,
        ST_RESET  = 3'd2,
        ST_PSET   = 3'd3,
        ST_SETTLE = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        DEN_1B  = 2'b00,
        DEN_2B  = 2'b01,
        DEN_4B  = 2'b10,
        DEN_ALT = 2'b11
    } density_e;

    localparam int NUM_DENS = 3;

endpackage

// File: rtl/mlc_window_calc.sv
module mlc_window_calc
    import mlc_pv_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int DATA_W = 4
) (
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [RES_W-1:0]  lo_o,
    output logic [RES_W-1:0]  hi_o
);

    logic [RES_W-1:0] lo_w [NUM_DENS];
    logic [RES_W-1:0] hi_w [NUM_DENS];

    // One window candidate per density: 1, 2 or 4 index bits on top.
    for (genvar g = 0; g < NUM_DENS; g++) begin : g_dens
        localparam int IDX_B = 1 << g;
        localparam int SH    = RES_W - IDX_B;
        logic [IDX_B-1:0] idx;
        assign idx      = data_i[IDX_B-1:0];
        assign lo_w[g]  = {idx, {SH{1'b0}}};
        assign hi_w[g]  = {idx, {SH{1'b1}}};
    end

    always_comb begin
        unique case (density_e'(mode_i))
            DEN_1B:  begin lo_o = lo_w[0]; hi_o = hi_w[0]; end
            DEN_2B:  begin lo_o = lo_w[1]; hi_o = hi_w[1]; end
            default: begin lo_o = lo_w[2]; hi_o = hi_w[2]; end
        endcase
    end

endmodule

// File: rtl/mlc_dwell_timer.sv
module mlc_dwell_timer #(
    parameter int TMR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TMR_W-1:0] val_i,
    output logic             expired_o
);

    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/mlc_pv_fsm.sv
module mlc_pv_fsm
    import mlc_pv_pkg::*;
#(
    parameter int PULSE_CYC  = 3,
    parameter int SETTLE_CYC = 2,
    parameter int RES_W      = 12,
    parameter int DATA_W     = 4,
    parameter int CNT_W      = 8,
    parameter int RETRY_W    = 4,
    parameter int TMR_W      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         mode_i,
    input  logic [DATA_W-1:0]  data_i,
    input  logic [CNT_W-1:0]   max_i,
    input  logic [RES_W-1:0]   res_i,
    input  logic [RES_W-1:0]   lo_i,
    input  logic [RES_W-1:0]   hi_i,
    input  logic               expired_i,
    output logic               load_o,
    output logic [TMR_W-1:0]   load_val_o,
    output logic [1:0]         mode_o,
    output logic [DATA_W-1:0]  data_o,
    output logic               sweep_o,
    output logic               reset_o,
    output logic               pset_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o,
    output logic [RETRY_W-1:0] retry_o
);

    localparam logic [TMR_W-1:0] PULSE_LD  = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [1:0]         mode;
        logic [DATA_W-1:0]  data;
        logic [CNT_W-1:0]   max;
        logic [CNT_W-1:0]   pcnt;
        logic [RETRY_W-1:0] retry;
        logic               done;
        logic               err;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      in_win, below_win, at_limit;

    assign in_win    = (res_i >= lo_i) && (res_i <= hi_i);
    assign below_win = (res_i < lo_i);
    assign at_limit  = (seq_q.pcnt >= seq_q.max);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        load_o     = 1'b0;
        load_val_o = PULSE_LD;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st    = ST_SWEEP;
                    seq_d.mode  = mode_i;
                    seq_d.data  = data_i;
                    seq_d.max   = max_i;
                    seq_d.pcnt  = '0;
                    seq_d.retry = '0;
                    load_o      = 1'b1;
                end
            end
            ST_SWEEP: begin
                if (expired_i) begin
                    seq_d.st = ST_RESET;
                    load_o   = 1'b1;
                end
            end
            ST_RESET: begin
                if (expired_i) begin
                    seq_d.st = ST_PSET;
                    load_o   = 1'b1;
                end
            end
            ST_PSET: begin
                if (expired_i) begin
                    seq_d.st   = ST_SETTLE;
                    load_o     = 1'b1;
                    load_val_o = SETTLE_LD;
                    if (seq_q.pcnt != '1) seq_d.pcnt = seq_q.pcnt + CNT_W'(1);
                end
            end
            ST_SETTLE: begin
                if (expired_i) begin
                    if (in_win) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end else if (at_limit) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                        seq_d.err  = 1'b1;
                    end else if (below_win) begin
                        seq_d.st = ST_SWEEP;
                        load_o   = 1'b1;
                        if (seq_q.retry != '1) seq_d.retry = seq_q.retry + RETRY_W'(1);
                    end else begin
                        seq_d.st = ST_PSET;
                        load_o   = 1'b1;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, mode: '0, data: '0, max: '0, pcnt: '0,
                       retry: '0, done: 1'b0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mode_o  = seq_q.mode;
    assign data_o  = seq_q.data;
    assign sweep_o = (seq_q.st == ST_SWEEP);
    assign reset_o = (seq_q.st == ST_RESET);
    assign pset_o  = (seq_q.st == ST_PSET);
    assign busy_o  = (seq_q.st != ST_IDLE);
    assign done_o  = seq_q.done;
    assign err_o   = seq_q.err;
    assign retry_o = seq_q.retry;

endmodule

// File: rtl/mlc_pv_seq.sv
module mlc_pv_seq #(
    parameter int PULSE_CYC  = 3,
    parameter int SETTLE_CYC = 2,
    parameter int RES_W      = 12,
    parameter int DATA_W     = 4,
    parameter int CNT_W      = 8,
    parameter int RETRY_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         mode_i,
    input  logic [DATA_W-1:0]  data_i,
    input  logic [CNT_W-1:0]   max_pulses_i,
    input  logic [RES_W-1:0]   res_i,
    output logic               sweep_o,
    output logic               reset_o,
    output logic               pset_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o,
    output logic [RETRY_W-1:0] retry_o
);

    localparam int MAX_DWELL = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
    localparam int TMR_W     = $clog2(MAX_DWELL) + 1;

    logic              tmr_load, tmr_exp;
    logic [TMR_W-1:0]  tmr_val;
    logic [1:0]        lat_mode;
    logic [DATA_W-1:0] lat_data;
    logic [RES_W-1:0]  win_lo, win_hi;

    mlc_window_calc #(.RES_W(RES_W), .DATA_W(DATA_W)) u_win (
        .mode_i (lat_mode),
        .data_i (lat_data),
        .lo_o   (win_lo),
        .hi_o   (win_hi)
    );

    mlc_dwell_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_exp)
    );

    mlc_pv_fsm #(
        .PULSE_CYC (PULSE_CYC),
        .SETTLE_CYC(SETTLE_CYC),
        .RES_W     (RES_W),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .RETRY_W   (RETRY_W),
        .TMR_W     (TMR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .data_i     (data_i),
        .max_i      (max_pulses_i),
        .res_i      (res_i),
        .lo_i       (win_lo),
        .hi_i       (win_hi),
        .expired_i  (tmr_exp),
        .load_o     (tmr_load),
        .load_val_o (tmr_val),
        .mode_o     (lat_mode),
        .data_o     (lat_data),
        .sweep_o    (sweep_o),
        .reset_o    (reset_o),
        .pset_o     (pset_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .retry_o    (retry_o)
    );

endmodule

// File: rtl/mlc_pv_seq_chk.sv
module mlc_pv_seq_chk #(
    parameter int RETRY_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               sweep_o,
    input logic               reset_o,
    input logic               pset_o,
    input logic               busy_o,
    input logic               done_o,
    input logic               err_o,
    input logic [RETRY_W-1:0] retry_o
);

    a_r2_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sweep_o, reset_o, pset_o}) <= 1);

    a_r2_reset_after_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sweep_o) |-> reset_o);

    a_r4_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(sweep_o || reset_o || pset_o));

    a_r5_retry_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sweep_o) && $past(busy_o)) |->
            ((retry_o == $past(retry_o) + RETRY_W'(1)) || ($past(retry_o) == '1)));

    a_r7_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    a_r8_idle_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r9_busy_drops_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

bind mlc_pv_seq mlc_pv_seq_chk #(.RETRY_W(RETRY_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .sweep_o (sweep_o),
    .reset_o (reset_o),
    .pset_o  (pset_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .retry_o (retry_o)
);

// File: tb/mlc_pv_seq_tb.sv
module mlc_pv_seq_tb;

    localparam int P = 3;
    localparam int S = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic [3:0] data_i = 4'd0;
    logic [7:0] max_pulses_i = 8'd0;
    logic [11:0] res_i;
    logic       sweep_o, reset_o, pset_o, busy_o, done_o, err_o;
    logic [3:0] retry_o;

    always #10 clk = ~clk;

    mlc_pv_seq #(.PULSE_CYC(P), .SETTLE_CYC(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .data_i(data_i), .max_pulses_i(max_pulses_i), .res_i(res_i),
        .sweep_o(sweep_o), .reset_o(reset_o), .pset_o(pset_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .retry_o(retry_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural cell model and command-timeline monitor.
    int cell_r = 0;
    int attempt = 0;
    int step_a = 0;
    int step_b = 0;
    int sw_rise = 0, rs_rise = 0, ps_rise = 0;
    int order_bad = 0, width_bad = 0, gap_bad = 0, busy_len = 0;
    int run_len = 0, gap_len = 0;
    bit gap_armed = 0;
    logic [2:0] cmd_prev = 3'b000;

    assign res_i = 12'(cell_r);

    always @(negedge clk) begin
        logic [2:0] cmd;
        cmd = {sweep_o, reset_o, pset_o};
        if (rst_n) begin
            if (busy_o) busy_len++;
            if (cmd[2] && !cmd_prev[2]) begin sw_rise++; gap_armed = 0; end
            if (cmd[0] && !cmd_prev[0]) begin
                ps_rise++;
                if (gap_armed && gap_len != S) gap_bad++;
                gap_armed = 0;
            end
            if (cmd[1] && !cmd_prev[1]) begin
                rs_rise++;
                if (!(cmd_prev[2] && !cmd[2])) order_bad++;
            end
            if (cmd != cmd_prev) begin
                if (cmd_prev != 3'b000 && run_len != P) width_bad++;
                run_len = (cmd != 3'b000) ? 1 : 0;
            end else if (cmd != 3'b000) begin
                run_len++;
            end
            if (cmd_prev[0] && !cmd[0]) begin
                gap_len = 1; gap_armed = 1;
                cell_r = (cell_r > ((attempt == 1) ? step_a : step_b)) ?
                         cell_r - ((attempt == 1) ? step_a : step_b) : 0;
            end else if (gap_armed && cmd == 3'b000) begin
                gap_len++;
            end
            if (cmd_prev[1] && !cmd[1]) begin
                cell_r = 4095; attempt++;
            end
        end
        cmd_prev = cmd;
    end

    task automatic model(input logic [1:0] m, input logic [3:0] d, input int mx,
                         input int sa, input int sb,
                         output int pulses, output int retries, output int err);
        int bits, w, idx, lo, hi, r, att, st;
        bits = (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
        w    = 4096 >> bits;
        idx  = int'(d) & ((1 << bits) - 1);
        lo   = idx * w;
        hi   = lo + w - 1;
        r = 4095; att = 1; pulses = 0; retries = 0; err = 0;
        for (int g = 0; g < 1000; g++) begin
            st = (att == 1) ? sa : sb;
            r  = (r > st) ? r - st : 0;
            pulses++;
            if (r >= lo && r <= hi) begin err = 0; break; end
            if (pulses >= mx) begin err = 1; break; end
            if (r < lo) begin r = 4095; retries++; att++; end
        end
    endtask

    task automatic run_write(string req, logic [1:0] m, logic [3:0] d, int mx,
                             int sa, int sb, bit poke);
        int ep, er, ee, cyc, busy_bad;
        model(m, d, mx, sa, sb, ep, er, ee);
        @(negedge clk);
        sw_rise = 0; rs_rise = 0; ps_rise = 0; order_bad = 0; width_bad = 0;
        gap_bad = 0; busy_len = 0; attempt = 0; step_a = sa; step_b = sb;
        gap_armed = 0;
        mode_i = m; data_i = d; max_pulses_i = 8'(mx); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9", "busy after start", int'(busy_o), 1);
        cyc = 0; busy_bad = 0;
        while (!done_o && cyc < 5000) begin
            if (!busy_o) busy_bad++;
            if (poke && cyc == 10) begin
                start_i = 1'b1; data_i = ~d; mode_i = ~m;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        chk(req, "done seen", int'(done_o), 1);
        chk("R9", "busy low at done", int'(busy_o), 0);
        chk("R9", "busy gaps", busy_bad, 0);
        chk(ee ? "R7" : "R4", "err flag", int'(err_o), ee);
        chk(req, "partial SET count", ps_rise, ep);
        chk("R5", "sweep count", sw_rise, er + 1);
        chk("R2", "reset count", rs_rise, er + 1);
        chk("R5", "retry count", int'(retry_o), er);
        chk("R2", "reset not right after sweep", order_bad, 0);
        chk("R3", "pulse width errors", width_bad, 0);
        chk("R3", "settle gap errors", gap_bad, 0);
        chk("R3", "busy cycles", busy_len, (er + 1) * 2 * P + ep * (P + S));
        @(negedge clk);
        chk("R9", "done single cycle", int'(done_o), 0);
        chk("R4", "no command after done", int'(sweep_o | reset_o | pset_o), 0);
    endtask

    task automatic t_reset;
        chk("R9", "reset busy", int'(busy_o), 0);
        chk("R9", "reset done", int'(done_o), 0);
        chk("R7", "reset err", int'(err_o), 0);
        chk("R2", "reset commands", int'({sweep_o, reset_o, pset_o}), 0);
        chk("R5", "reset retry", int'(retry_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R1: one-bit upper slice reached on the first pulse
        run_write("R1", 2'b00, 4'd1, 20, 100, 100, 1'b0);
        // R10: upper data bits ignored, one-bit slice 0
        run_write("R10", 2'b00, 4'b1110, 20, 500, 500, 1'b0);
        // R6: two-bit slice 2 walked down from above
        run_write("R6", 2'b01, 4'd2, 20, 300, 300, 1'b0);
        // R1: four-bit slice 5
        run_write("R1", 2'b10, 4'd5, 20, 300, 300, 1'b0);
        // R1: alternate encoding 11 behaves as four-bit
        run_write("R1", 2'b11, 4'd5, 20, 300, 300, 1'b0);
        // R5: overshoot then restart with finer step
        run_write("R5", 2'b10, 4'd2, 40, 1000, 200, 1'b0);
        // R7: limit reached before window
        run_write("R7", 2'b10, 4'd0, 5, 10, 10, 1'b0);
        // R7: limit 0 acts as 1
        run_write("R7", 2'b01, 4'd0, 0, 10, 10, 1'b0);
        // R7: limit counted across two restarts
        run_write("R7", 2'b10, 4'd2, 10, 1000, 1000, 1'b0);
        // R8: start during busy ignored
        run_write("R8", 2'b01, 4'd2, 20, 300, 300, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule